// File: doc/BRIEF.md
# Level-Masked Prioritised Interrupt Controller

This block gathers interrupt events from a set of peripheral sources and decides which one, if any, the processor takes next. Each source keeps a pending flag, which an event sets and a software write clears, and a control register holding an enable bit and a 3-bit urgency level. A source with its flag set and its enable set raises a request. The arbiter picks the most urgent request and presents its level and source index at all times.

A processor-side acceptance unit holds the current level mask. A request is taken only when three things are true:

- its level is numerically below the mask;
- the global interrupt enable input is high;
- an instruction-boundary strobe arrives.

On acceptance the unit pushes a frame onto an internal LIFO and then raises the mask to the accepted level. The frame holds the status word, the program counter and the old mask. A return strobe pops the newest frame and restores all three. The LIFO lets handlers nest. Two sticky flags record a push attempted into a full stack and a pop from an empty one.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the mask reads 7, every pending flag, enable bit, pulse, error flag, `acc_vector`, `pc_out` and `ps_out` read 0, and every source level reads 7.
- R2: A source requests only while its pending flag and enable bit are both 1 and its level is not 7. A source at level 7 never drives `req_valid`.
- R3: Among requesting sources, `req_level`/`req_vector` combinationally show the numerically smallest level. Equal levels go to the lowest source index. `req_valid` is 0 when nothing requests.
- R4: A request qualifies only when `req_level` < `ilm` and `gie` = 1. A request that does not qualify is never accepted.
- R5: A qualifying request is accepted at a clock edge where `insn_done` = 1, provided `reti` = 0 and the stack is not full. In the next cycle:
  - `accept_pulse` is 1 for exactly that cycle;
  - `acc_vector` equals the winning source index;
  - `ilm` equals the accepted level.
- R6: Acceptance pushes {`ps_in`, `pc_in`, old `ilm`}. A `reti` with a non-empty stack pops the newest frame. In the next cycle `ret_pulse` is 1 for one cycle and `ilm`, `pc_out` and `ps_out` carry the popped values.
- R7: When `reti` and `insn_done` are both 1 in the same cycle, the return is performed and no acceptance happens in that cycle.
- R8: When a request qualifies at a boundary while the stack holds DEPTH frames, nothing is accepted, `ilm` is unchanged, and `ovf_err` becomes 1 and stays 1 until reset.
- R9: A `reti` with an empty stack gives no `ret_pulse` and leaves `ilm` unchanged. It sets `unf_err`, which stays 1 until reset.
- R10: A 1 on `src_evt[i]` sets flag i from the next cycle. `clr_we` with `clr_idx` = i clears it. When both happen in the same cycle, the set wins.
- R11: `cfg_we` writes `cfg_en` and `cfg_lvl` into the control register of source `cfg_idx`. The new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NSRC | Per-source event strobes that set pending flags |
| cfg_we | input | 1 | Control register write strobe |
| cfg_idx | input | IDX_W | Source selected for the control write |
| cfg_en | input | 1 | Enable value written |
| cfg_lvl | input | LVL_W | Level value written |
| clr_we | input | 1 | Pending flag clear strobe |
| clr_idx | input | IDX_W | Source whose flag is cleared |
| gie | input | 1 | Global interrupt enable flag |
| insn_done | input | 1 | Instruction boundary strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| pc_in | input | PC_W | Current program counter |
| ps_in | input | PS_W | Current status word |
| req_valid | output | 1 | Some source is requesting |
| req_level | output | LVL_W | Level of the winning request |
| req_vector | output | IDX_W | Index of the winning request |
| ilm | output | LVL_W | Current level mask |
| accept_pulse | output | 1 | One-cycle acceptance pulse |
| acc_vector | output | IDX_W | Source index last accepted |
| ret_pulse | output | 1 | One-cycle return pulse |
| pc_out | output | PC_W | Program counter restored by the last return |
| ps_out | output | PS_W | Status word restored by the last return |
| ovf_err | output | 1 | Sticky stack overflow flag |
| unf_err | output | 1 | Sticky stack underflow flag |

## Verification
The bench builds the block with four sources and a stack two frames deep. With four sources, every tie between equal levels and the level-7 exclusion can be set up by a handful of control writes. With a two-frame stack, overflow arrives after only two nested acceptances, and underflow follows quickly from returns in the random phase. This keeps the full-stack refusal and both sticky flags well inside a few thousand random cycles.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  parameter int LVL_W = 3;

  // true when level a is more urgent than level b (smaller wins)
  function automatic logic lvl_beats(input logic [LVL_W-1:0] a,
                                     input logic [LVL_W-1:0] b);
    return a < b;
  endfunction

  // the all-ones level marks a source as switched off
  function automatic logic lvl_off(input logic [LVL_W-1:0] l);
    return &l;
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_lvl_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       src_evt,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic                  cfg_en,
  input  logic [LVL_W-1:0]      cfg_lvl,
  input  logic                  clr_we,
  input  logic [IDX_W-1:0]      clr_idx,
  output logic [NSRC-1:0]       req_vec,
  output logic [NSRC*LVL_W-1:0] lvl_flat
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic             pend_q;
    logic             en_q;
    logic [LVL_W-1:0] lvl_q;
    logic             sel_cfg;
    logic             sel_clr;

    assign sel_cfg = cfg_we && (cfg_idx == IDX_W'(g));
    assign sel_clr = clr_we && (clr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        en_q   <= 1'b0;
        lvl_q  <= '1;
      end else begin
        if (src_evt[g])   pend_q <= 1'b1;
        else if (sel_clr) pend_q <= 1'b0;
        if (sel_cfg) begin
          en_q  <= cfg_en;
          lvl_q <= cfg_lvl;
        end
      end
    end

    assign req_vec[g] = pend_q && en_q && !lvl_off(lvl_q);
    assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_lvl_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]       req_vec,
  input  logic [NSRC*LVL_W-1:0] lvl_flat,
  output logic                  win_valid,
  output logic [LVL_W-1:0]      win_lvl,
  output logic [IDX_W-1:0]      win_idx
);
  // scan from the top index down; "<=" lets a lower index take a tie
  always_comb begin
    win_valid = 1'b0;
    win_lvl   = '1;
    win_idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_vec[i] &&
          (!win_valid || !lvl_beats(win_lvl, lvl_flat[i*LVL_W +: LVL_W]))) begin
        win_valid = 1'b1;
        win_lvl   = lvl_flat[i*LVL_W +: LVL_W];
        win_idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_stack.sv
module irq_stack #(
  parameter int W     = 27,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data,
  output logic         full,
  output logic         empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] top_pos;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign top_pos = cnt - 1'b1;
  assign top_data = empty ? '0 : mem[top_pos[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end else if (push && !full) begin
      mem[cnt[PTR_W-1:0]] <= push_data;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_lvl_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic [IDX_W-1:0] req_vector,
  input  logic             gie,
  input  logic             insn_done,
  input  logic             reti,
  input  logic             stk_full,
  input  logic             stk_empty,
  input  logic [LVL_W-1:0] pop_ilm,
  output logic [LVL_W-1:0] ilm,
  output logic             accept_fire,
  output logic             ret_fire,
  output logic             accept_pulse,
  output logic [IDX_W-1:0] acc_vector,
  output logic             ret_pulse,
  output logic             ovf_err,
  output logic             unf_err
);
  logic qualify;
  logic accept_try;

  assign qualify     = req_valid && gie && lvl_beats(req_level, ilm);
  assign ret_fire    = reti && !stk_empty;
  assign accept_try  = insn_done && qualify && !reti;
  assign accept_fire = accept_try && !stk_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ilm          <= '1;
      accept_pulse <= 1'b0;
      ret_pulse    <= 1'b0;
      acc_vector   <= '0;
      ovf_err      <= 1'b0;
      unf_err      <= 1'b0;
    end else begin
      accept_pulse <= accept_fire;
      ret_pulse    <= ret_fire;
      if (ret_fire) begin
        ilm <= pop_ilm;
      end else if (accept_fire) begin
        ilm        <= req_level;
        acc_vector <= req_vector;
      end
      if (accept_try && stk_full) ovf_err <= 1'b1;
      if (reti && stk_empty)      unf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int DEPTH = 4,
  parameter int PC_W  = 16,
  parameter int PS_W  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_evt,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_en,
  input  logic [LVL_W-1:0] cfg_lvl,
  input  logic             clr_we,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             gie,
  input  logic             insn_done,
  input  logic             reti,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [PS_W-1:0]  ps_in,
  output logic             req_valid,
  output logic [LVL_W-1:0] req_level,
  output logic [IDX_W-1:0] req_vector,
  output logic [LVL_W-1:0] ilm,
  output logic             accept_pulse,
  output logic [IDX_W-1:0] acc_vector,
  output logic             ret_pulse,
  output logic [PC_W-1:0]  pc_out,
  output logic [PS_W-1:0]  ps_out,
  output logic             ovf_err,
  output logic             unf_err
);
  localparam int FRAME_W = PS_W + PC_W + LVL_W;

  logic [NSRC-1:0]       req_vec;
  logic [NSRC*LVL_W-1:0] lvl_flat;
  logic                  accept_fire;
  logic                  ret_fire;
  logic                  stk_full;
  logic                  stk_empty;
  logic [FRAME_W-1:0]    push_frame;
  logic [FRAME_W-1:0]    top_frame;

  irq_src_bank #(.NSRC(NSRC), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_lvl(cfg_lvl),
    .clr_we(clr_we), .clr_idx(clr_idx),
    .req_vec(req_vec), .lvl_flat(lvl_flat)
  );

  irq_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .req_vec(req_vec), .lvl_flat(lvl_flat),
    .win_valid(req_valid), .win_lvl(req_level), .win_idx(req_vector)
  );

  assign push_frame = {ps_in, pc_in, ilm};

  irq_stack #(.W(FRAME_W), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n),
    .push(accept_fire), .pop(ret_fire),
    .push_data(push_frame), .top_data(top_frame),
    .full(stk_full), .empty(stk_empty)
  );

  irq_accept #(.IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_level(req_level), .req_vector(req_vector),
    .gie(gie), .insn_done(insn_done), .reti(reti),
    .stk_full(stk_full), .stk_empty(stk_empty),
    .pop_ilm(top_frame[LVL_W-1:0]),
    .ilm(ilm), .accept_fire(accept_fire), .ret_fire(ret_fire),
    .accept_pulse(accept_pulse), .acc_vector(acc_vector),
    .ret_pulse(ret_pulse), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_out <= '0;
      ps_out <= '0;
    end else if (ret_fire) begin
      pc_out <= top_frame[LVL_W +: PC_W];
      ps_out <= top_frame[LVL_W+PC_W +: PS_W];
    end
  end
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
  import irq_lvl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic             insn_done,
  input logic             reti,
  input logic             req_valid,
  input logic [LVL_W-1:0] req_level,
  input logic [LVL_W-1:0] ilm,
  input logic             accept_pulse,
  input logic             ret_pulse,
  input logic             ovf_err,
  input logic             unf_err,
  input logic             accept_fire,
  input logic             stk_empty
);
  AST_LVL7_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !(&req_level)); // R2
  AST_ACC_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire |-> (gie && req_level < ilm)); // R4
  AST_ACC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire |-> insn_done); // R5
  AST_ACC_RAISES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire |=> (accept_pulse && ilm == $past(req_level))); // R5
  AST_RET_BEFORE_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    reti |-> !accept_fire); // R7
  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_pulse && ret_pulse)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R8
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |=> unf_err); // R9
  AST_EMPTY_RET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && stk_empty) |=> (!ret_pulse && unf_err && $stable(ilm))); // R9
endmodule

bind irq_level_ctrl irq_level_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .insn_done(insn_done), .reti(reti),
  .req_valid(req_valid), .req_level(req_level), .ilm(ilm),
  .accept_pulse(accept_pulse), .ret_pulse(ret_pulse),
  .ovf_err(ovf_err), .unf_err(unf_err),
  .accept_fire(accept_fire), .stk_empty(stk_empty)
);

// File: tb/tb_irq_level_ctrl.sv
module tb_irq_level_ctrl;
  localparam int NSRC = 4;
  localparam int DEPTH = 2;
  localparam int PC_W = 16;
  localparam int PS_W = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_evt = '0;
  logic cfg_we = 0, cfg_en = 0, clr_we = 0, gie = 0, insn_done = 0, reti = 0;
  logic [IW-1:0] cfg_idx = '0, clr_idx = '0;
  logic [2:0] cfg_lvl = '0;
  logic [PC_W-1:0] pc_in = '0;
  logic [PS_W-1:0] ps_in = '0;
  logic req_valid, accept_pulse, ret_pulse, ovf_err, unf_err;
  logic [2:0] req_level, ilm;
  logic [IW-1:0] req_vector, acc_vector;
  logic [PC_W-1:0] pc_out;
  logic [PS_W-1:0] ps_out;

  irq_level_ctrl #(.NSRC(NSRC), .DEPTH(DEPTH), .PC_W(PC_W), .PS_W(PS_W)) dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_lvl(cfg_lvl), .clr_we(clr_we),
    .clr_idx(clr_idx), .gie(gie), .insn_done(insn_done), .reti(reti),
    .pc_in(pc_in), .ps_in(ps_in), .req_valid(req_valid), .req_level(req_level),
    .req_vector(req_vector), .ilm(ilm), .accept_pulse(accept_pulse),
    .acc_vector(acc_vector), .ret_pulse(ret_pulse), .pc_out(pc_out),
    .ps_out(ps_out), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;

  // reference model state
  bit m_flag [NSRC];
  bit m_en [NSRC];
  int m_lvl [NSRC];
  int m_ilm, m_accv, m_pc, m_ps, m_sp;
  bit m_accp, m_retp, m_ovf, m_unf;
  int s_ilm [DEPTH];
  int s_pc [DEPTH];
  int s_ps [DEPTH];

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pick_best(output int lvl);
    int bi = -1;
    lvl = 7;
    for (int i = 0; i < NSRC; i++)
      if (m_flag[i] && m_en[i] && m_lvl[i] != 7 && (bi < 0 || m_lvl[i] < lvl)) begin
        bi = i;
        lvl = m_lvl[i];
      end
    return bi;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NSRC; i++) begin
      m_flag[i] = 0; m_en[i] = 0; m_lvl[i] = 7;
    end
    m_ilm = 7; m_accv = 0; m_pc = 0; m_ps = 0; m_sp = 0;
    m_accp = 0; m_retp = 0; m_ovf = 0; m_unf = 0;
  endtask

  task automatic compare_all();
    int bl, bi;
    bi = pick_best(bl);
    check("R3 req_valid", int'(req_valid), int'(bi >= 0));
    if (bi >= 0) begin
      check("R3 req_level", int'(req_level), bl);
      check("R3 req_vector", int'(req_vector), bi);
    end
    check("R5 ilm", int'(ilm), m_ilm);
    check("R5 accept_pulse", int'(accept_pulse), int'(m_accp));
    check("R5 acc_vector", int'(acc_vector), m_accv);
    check("R6 ret_pulse", int'(ret_pulse), int'(m_retp));
    check("R6 pc_out", int'(pc_out), m_pc);
    check("R6 ps_out", int'(ps_out), m_ps);
    check("R8 ovf_err", int'(ovf_err), int'(m_ovf));
    check("R9 unf_err", int'(unf_err), int'(m_unf));
  endtask

  // one clock: model decides from pre-edge state, then compare after edge
  task automatic tick();
    int bl, bi;
    bit qual;
    bi = pick_best(bl);
    qual = (bi >= 0) && (bl < m_ilm) && gie;
    m_accp = 0; m_retp = 0;
    if (reti) begin
      if (m_sp > 0) begin
        m_sp--;
        m_ilm = s_ilm[m_sp]; m_pc = s_pc[m_sp]; m_ps = s_ps[m_sp];
        m_retp = 1;
      end else m_unf = 1;
    end else if (insn_done && qual) begin
      if (m_sp == DEPTH) m_ovf = 1;
      else begin
        s_ilm[m_sp] = m_ilm; s_pc[m_sp] = int'(pc_in); s_ps[m_sp] = int'(ps_in);
        m_sp++;
        m_ilm = bl; m_accv = bi; m_accp = 1;
      end
    end
    for (int i = 0; i < NSRC; i++) begin
      if (clr_we && int'(clr_idx) == i) m_flag[i] = 0;
      if (src_evt[i]) m_flag[i] = 1;
    end
    if (cfg_we) begin
      m_en[cfg_idx] = cfg_en;
      m_lvl[cfg_idx] = int'(cfg_lvl);
    end
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic idle();
    src_evt = '0; cfg_we = 0; clr_we = 0; insn_done = 0; reti = 0;
  endtask

  task automatic cfg(int idx, bit en, int lvl);
    idle();
    cfg_we = 1; cfg_idx = IW'(idx); cfg_en = en; cfg_lvl = 3'(lvl);
    tick();
    idle();
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    bit v;
    seed = 32'h1F2E3D4C;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    compare_all(); // R1 reset state
    check("R1 ilm after reset", int'(ilm), 7);

    // R11 configuration, R2 enable gating
    cfg(0, 1, 5); cfg(1, 1, 2); cfg(2, 1, 2); cfg(3, 1, 7);
    idle(); src_evt = 4'b1000; tick(); idle();
    check("R2 level-7 source silent", int'(req_valid), 0);
    src_evt = 4'b0111; tick(); idle();
    check("R3 tie goes to lowest index", int'(req_vector), 1);
    cfg(1, 0, 2);
    check("R11 disable takes effect", int'(req_vector), 2);

    // R4 gie low blocks
    gie = 0; insn_done = 1; tick(); idle();
    check("R4 gie=0 no accept", int'(accept_pulse), 0);
    // R5 accept without boundary is held
    gie = 1; tick();
    check("R5 no boundary no accept", int'(accept_pulse), 0);
    pc_in = 16'h1234; ps_in = 8'h5A; insn_done = 1; tick(); idle();
    check("R5 accepted vector", int'(acc_vector), 2);
    check("R5 mask raised", int'(ilm), 2);
    // R4 source 0 at level 5 does not beat mask 2
    clr_we = 1; clr_idx = 2; tick(); idle();
    insn_done = 1; tick(); idle();
    check("R4 weaker level refused", int'(accept_pulse), 0);
    // R10 set wins over clear
    clr_we = 1; clr_idx = 0; src_evt = 4'b0001; tick(); idle();
    check("R10 set wins over clear", int'(req_vector), 0);
    clr_we = 1; clr_idx = 0; tick(); idle();
    check("R10 clear removes request", int'(req_valid), 0);
    // R7 reti and boundary together: return wins
    cfg(1, 1, 1); src_evt = 4'b0010; tick(); idle();
    reti = 1; insn_done = 1; tick(); idle();
    check("R7 return taken", int'(ret_pulse), 1);
    check("R7 no accept with return", int'(accept_pulse), 0);
    check("R6 pc restored", int'(pc_out), 16'h1234);
    check("R6 ps restored", int'(ps_out), 8'h5A);
    // R8 nest to full and overflow
    cfg(0, 1, 0);
    insn_done = 1; tick(); idle(); // accepts src1 level 1
    src_evt = 4'b0001; tick(); idle();
    insn_done = 1; tick(); idle(); // accepts src0 level 0, stack full
    check("R8 nested mask", int'(ilm), 0);
    m_ilm = m_ilm; // ilm 0 blocks all; force a qualifying request by popping once
    reti = 1; tick(); idle();
    insn_done = 1; tick(); idle(); // src0 level 0 reaccepted, full again
    cfg(2, 1, 0); src_evt = 4'b0100; tick(); idle();
    reti = 1; tick(); idle(); // pop to ilm 1
    insn_done = 1; tick(); idle(); // push, full
    check("R8 full stack nested", int'(accept_pulse), 1);
    reti = 1; tick(); idle();
    reti = 1; tick(); idle();
    reti = 1; tick(); idle();
    check("R9 underflow flagged", int'(unf_err), 1);
    insn_done = 1; tick(); idle();
    insn_done = 1; tick(); idle();
    insn_done = 1; tick(); idle();
    check("R8 overflow sticky", int'(ovf_err), int'(m_ovf));

    // random phase
    for (int c = 0; c < 3000; c++) begin
      idle();
      for (int i = 0; i < NSRC; i++) src_evt[i] = ($urandom % 6) == 0;
      v = ($urandom % 5) == 0;
      cfg_we = v; cfg_idx = IW'($urandom); cfg_en = ($urandom % 4) != 0;
      cfg_lvl = 3'($urandom);
      clr_we = ($urandom % 3) == 0; clr_idx = IW'($urandom);
      gie = ($urandom % 8) != 0;
      insn_done = $urandom % 2;
      reti = ($urandom % 7) == 0;
      pc_in = PC_W'($urandom); ps_in = PS_W'($urandom);
      tick();
    end
    idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule